// File: doc/BRIEF.md
# Double-Buffered Receive Message Handoff

This block sits between a bus receiver and a CPU. Each completed, correctly received message (identifier, length code and up to a parameterised number of data bytes) is written into a staging buffer. When the CPU-visible buffer is free, the staged message moves into it on the next clock. A ready flag then rises and stays up until the CPU writes one to release the buffer. While the ready flag is up, the staged message is held back. A further message that arrives while both buffers are occupied is discarded, and a sticky overrun flag records the loss.

The CPU reads the visible buffer through a byte-addressed read port, alongside the identifier and length. These outputs carry data only while the ready flag is set. Two enable inputs gate the ready flag onto a receive interrupt and the overrun flag onto an error interrupt.

Top module: `rx_dbuf_handshake`

## Requirements
- R1: After reset is asserted, `rdy_flag`, `ovr_flag`, `rx_irq` and `err_irq` are 0, and both buffers are empty.
- R2: A message presented with `msg_valid` high at a clock edge is stored in the staging buffer when that buffer is empty or is being moved at the same edge. A staged message moves to the visible buffer at the next edge at which `rdy_flag` is 0, and `rdy_flag` is 1 after that edge.
- R3: While `rdy_flag` is 1, the visible buffer contents (identifier, length, data) do not change.
- R4: A 1 on `rdy_clr` at an edge where `rdy_flag` is 1 makes `rdy_flag` 0 after that edge. A 1 on `rdy_clr` while `rdy_flag` is 0 has no effect.
- R5: If the staging buffer holds a message when `rdy_flag` is cleared, that message moves to the visible buffer at the following edge and `rdy_flag` returns to 1.
- R6: A message that arrives while the staging buffer is occupied and `rdy_flag` is 1 is discarded, and `ovr_flag` becomes 1. The staged and visible messages are kept.
- R7: `ovr_flag` stays set until a 1 on `ovr_clr`. A new overrun at the same edge wins over the clear. Clearing either flag does not affect the other flag.
- R8: `rx_irq` is 1 exactly when `rdy_flag` and `rx_ie` are both 1.
- R9: `err_irq` is 1 exactly when `ovr_flag` and `err_ie` are both 1.
- R10: While `rdy_flag` is 1, `rd_data` returns data byte `rd_addr`. Byte k is bits 8k+7..8k of `msg_data`. For `rd_addr` at or above the byte count, `rd_data` is 0. `rd_id` and `rd_len` return the visible message's fields. While `rdy_flag` is 0, all three read outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | A correctly received message is present this cycle |
| msg_id | input | ID_W | Message identifier |
| msg_len | input | LEN_W | Message length code |
| msg_data | input | 8*NBYTES | Message data bytes, byte 0 in the low bits |
| rd_addr | input | ADDR_W | CPU byte select for the visible buffer |
| rd_data | output | 8 | Selected visible data byte |
| rd_id | output | ID_W | Visible message identifier |
| rd_len | output | LEN_W | Visible message length code |
| rdy_clr | input | 1 | Write-one strobe releasing the visible buffer |
| ovr_clr | input | 1 | Write-one strobe clearing the overrun flag |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| rdy_flag | output | 1 | Visible buffer holds an unread message |
| ovr_flag | output | 1 | A message was lost to overrun |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Error interrupt |

## Verification
The bench builds the block with two data bytes, a 4-bit identifier and a 2-bit length code, which gives a 2-bit read address. Two of the four addresses are therefore out of range, so the zero return for them is reached on every read sweep. With this configuration, each cycle's check can sweep every read address and compare it against a payload computed from the message sequence number. A long pseudo-random stream of valid, clear and enable inputs drives the staging and ready flags through all four occupancy states combined with every input pattern. That stream reaches overrun with a simultaneous clear, and refill directly after release.

// File: rtl/rx_dbuf_handshake.sv
module rx_dbuf_handshake #(
  parameter int ID_W   = 11,
  parameter int LEN_W  = 4,
  parameter int NBYTES = 8,
  parameter int ADDR_W = $clog2(NBYTES) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  msg_valid,
  input  logic [ID_W-1:0]       msg_id,
  input  logic [LEN_W-1:0]      msg_len,
  input  logic [8*NBYTES-1:0]   msg_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [7:0]            rd_data,
  output logic [ID_W-1:0]       rd_id,
  output logic [LEN_W-1:0]      rd_len,
  input  logic                  rdy_clr,
  input  logic                  ovr_clr,
  input  logic                  rx_ie,
  input  logic                  err_ie,
  output logic                  rdy_flag,
  output logic                  ovr_flag,
  output logic                  rx_irq,
  output logic                  err_irq
);
  localparam int DW = 8 * NBYTES;
  localparam int IW = ADDR_W + 3;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NBYTES - 1);

  logic              stg_valid;
  logic [ID_W-1:0]   stg_id,   vis_id;
  logic [LEN_W-1:0]  stg_len,  vis_len;
  logic [DW-1:0]     stg_data, vis_data;

  logic move, drop, take;
  assign move = stg_valid & ~rdy_flag;
  assign drop = msg_valid & stg_valid & rdy_flag;
  assign take = msg_valid & ~drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_flag  <= 1'b0;
      stg_valid <= 1'b0;
      ovr_flag  <= 1'b0;
    end else begin
      if (move)         rdy_flag <= 1'b1;
      else if (rdy_clr) rdy_flag <= 1'b0;

      if (take)         stg_valid <= 1'b1;
      else if (move)    stg_valid <= 1'b0;

      if (drop)         ovr_flag <= 1'b1;
      else if (ovr_clr) ovr_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      stg_id   <= msg_id;
      stg_len  <= msg_len;
      stg_data <= msg_data;
    end
    if (move) begin
      vis_id   <= stg_id;
      vis_len  <= stg_len;
      vis_data <= stg_data;
    end
  end

  logic [IW-1:0] bit_idx;
  logic [7:0]    byte_sel;
  assign bit_idx  = {rd_addr, 3'b000};
  assign byte_sel = (rd_addr <= LAST) ? vis_data[bit_idx +: 8] : 8'h00;

  assign rd_data = rdy_flag ? byte_sel : 8'h00;
  assign rd_id   = rdy_flag ? vis_id   : '0;
  assign rd_len  = rdy_flag ? vis_len  : '0;
  assign rx_irq  = rdy_flag & rx_ie;
  assign err_irq = ovr_flag & err_ie;

  a_r3_vis_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_flag && !rdy_clr |=> rdy_flag && $stable(vis_id) && $stable(vis_len) && $stable(vis_data));

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_flag && rdy_clr |=> !rdy_flag);

  a_r5_refill: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_flag && stg_valid |=> rdy_flag);

  a_r6_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && stg_valid && rdy_flag |=> ovr_flag && stg_valid && $stable(stg_id) && $stable(stg_data));

  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag && !ovr_clr |=> ovr_flag);

  a_r2_stage_fill: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> stg_valid);
endmodule

// File: tb/rx_dbuf_handshake_test.sv
module rx_dbuf_handshake_test;
  localparam int ID_W = 4, LEN_W = 2, NB = 2, AW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, msg_valid, rdy_clr, ovr_clr, rx_ie, err_ie;
  logic [ID_W-1:0] msg_id, rd_id;
  logic [LEN_W-1:0] msg_len, rd_len;
  logic [8*NB-1:0] msg_data;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data;
  logic rdy_flag, ovr_flag, rx_irq, err_irq;

  rx_dbuf_handshake #(.ID_W(ID_W), .LEN_W(LEN_W), .NBYTES(NB), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_id(msg_id), .msg_len(msg_len),
    .msg_data(msg_data), .rd_addr(rd_addr), .rd_data(rd_data), .rd_id(rd_id), .rd_len(rd_len),
    .rdy_clr(rdy_clr), .ovr_clr(ovr_clr), .rx_ie(rx_ie), .err_ie(err_ie),
    .rdy_flag(rdy_flag), .ovr_flag(ovr_flag), .rx_irq(rx_irq), .err_irq(err_irq));

  int checks = 0, fails = 0;
  bit mf = 0, mb = 0, mo = 0;
  int vis_n = 0, stg_n = 0, seq = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_byte(int n, int k);
    if (k == 0) return (n * 7 + 5) & 255;
    if (k == 1) return (n * 3 + 1) & 255;
    return 0;
  endfunction

  task automatic drive_payload();
    msg_id   = ID_W'(seq);
    msg_len  = LEN_W'(seq);
    msg_data = {8'(exp_byte(seq, 1)), 8'(exp_byte(seq, 0))};
  endtask

  task automatic compare_all();
    chk("R2 rdy_flag", rdy_flag, mf);
    chk("R6 ovr_flag", ovr_flag, mo);
    chk("R8 rx_irq", rx_irq, mf & rx_ie);
    chk("R9 err_irq", err_irq, mo & err_ie);
    for (int a = 0; a < 4; a++) begin
      rd_addr = AW'(a);
      #1;
      chk("R10 rd_data", rd_data, mf ? exp_byte(vis_n, a) : 0);
    end
    chk("R10 rd_id", rd_id, mf ? (vis_n & 15) : 0);
    chk("R10 rd_len", rd_len, mf ? (vis_n & 3) : 0);
  endtask

  task automatic step(bit v, bit clr, bit oclr);
    bit pf, pb, po, mv, dr;
    msg_valid = v; rdy_clr = clr; ovr_clr = oclr;
    drive_payload();
    @(posedge clk);
    #1;
    pf = mf; pb = mb; po = mo;
    mv = pb && !pf;
    dr = v && pb && pf;
    if (mv) vis_n = stg_n;
    mf = mv ? 1'b1 : (pf && !clr);
    if (dr) mb = 1;
    else if (v) begin stg_n = seq; mb = 1; end
    else mb = pb && !mv;
    mo = dr ? 1'b1 : (po && !oclr);
    if (v) seq++;
    @(negedge clk);
    msg_valid = 0; rdy_clr = 0; ovr_clr = 0;
    compare_all();
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr;
    rst_n = 0; msg_valid = 0; rdy_clr = 0; ovr_clr = 0; rx_ie = 1; err_ie = 1; rd_addr = 0;
    drive_payload();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 rdy_flag reset", rdy_flag, 0);
    chk("R1 ovr_flag reset", ovr_flag, 0);
    chk("R1 rx_irq reset", rx_irq, 0);
    chk("R1 err_irq reset", err_irq, 0);
    rst_n = 1;

    step(1, 0, 0);
    chk("R2 not yet visible", rdy_flag, 0);
    step(0, 0, 0);
    chk("R2 moved", rd_id, 0);
    step(1, 0, 0);
    chk("R3 visible held", rd_id, 0);
    step(1, 1, 0);
    chk("R6 overrun on clear edge", ovr_flag, 1);
    chk("R4 released", rdy_flag, 0);
    step(0, 0, 0);
    chk("R5 refilled", rdy_flag, 1);
    chk("R5 refill id", rd_id, 1);
    step(0, 0, 1);
    chk("R7 ovr cleared", ovr_flag, 0);
    chk("R7 rdy kept", rdy_flag, 1);
    step(0, 1, 0);
    step(0, 1, 0);
    chk("R4 clear when empty", rdy_flag, 0);

    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rx_ie = lfsr[3]; err_ie = lfsr[7];
      step(lfsr[0] | lfsr[5], lfsr[1] & lfsr[9], lfsr[2] & lfsr[4] & lfsr[11]);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule